// File: doc/BRIEF.md
# Tagged bidirectional parallel-port FIFO

This block is the 16-entry byte queue that sits between the host register interface of an extended-capabilities parallel port and its peripheral-side handshake engine. Every entry carries a ninth bit that marks the byte as a command (1) or as data (0). The queue runs in one of two directions. In the forward direction the host fills it and the peripheral side drains it. In the reverse direction the peripheral side fills it and the host drains it.

The host reaches the queue through four register aliases, chosen by `host_sel_i`. All four aliases share the same storage. Each alias works only in particular values of the 3-bit port mode field. An access through an alias that is closed in the current mode does nothing. A write to a full queue is dropped. A read from an empty queue returns zero. Neither of these moves a pointer or changes a flag. The peripheral side connects through a plain push/pop port. The block also reports empty and full, and raises a threshold interrupt that follows free space in the forward direction and filled space in the reverse direction.

Top module: `pp_tag_fifo`

## Requirements
- R1: After reset, `empty_o`=1 and `full_o`=0, and both `host_rdata_o` and `per_pdata_o` read zero.
- R2: In the forward direction, bytes written by the host come out on `per_pdata_o`/`per_ptag_o` in first-in, first-out order, and `per_pop_i` advances the head. Alias 0 (command) tags the byte with 1. Aliases 1 and 2 (data) tag it with 0.
- R3: With 16 entries stored, `full_o`=1. A further write is discarded, and the stored contents and the flags stay as they were.
- R4: A pop or read on an empty queue returns zero, leaves `empty_o` at 1 and does not move the pointers, so the next byte written is the next byte read.
- R5: In the reverse direction, in mode 3'b011, host reads through alias 2 return the bytes pushed on the peripheral side, in order and with their tags.
- R6: Alias 1 accepts writes only in mode 3'b010. Aliases 0 and 2 work only in mode 3'b011. In any other mode, writes through them are ignored.
- R7: In mode 3'b110, alias 3 (test) both writes (tag 0) and reads the queue in either direction, and the peripheral port is inactive.
- R8: Host writes outside the test alias work only in the forward direction. Peripheral pushes work only in the reverse direction. Peripheral pops work only in the forward direction.
- R9: In the forward direction, `thresh_irq_o` is 1 exactly when (16 − stored entries) ≥ `thresh_i`.
- R10: In the reverse direction, `thresh_irq_o` is 1 exactly when the number of stored entries ≥ `thresh_i`.
- R11: A host read through a closed alias, or in the wrong direction, returns zero on `host_rdata_o`/`host_rtag_o` and consumes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Port mode field |
| dir_rev_i | input | 1 | 0 forward (host fills), 1 reverse (host drains) |
| thresh_i | input | 4 | Interrupt threshold |
| host_sel_i | input | 2 | Alias: 0 command, 1 compatible data, 2 ECP data, 3 test |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte (zero when the read is not valid) |
| host_rtag_o | output | 1 | Tag of the host read byte |
| per_push_i | input | 1 | Peripheral push strobe |
| per_pdata_i | input | 8 | Peripheral push byte |
| per_ptag_i | input | 1 | Peripheral push tag |
| per_pop_i | input | 1 | Peripheral pop strobe |
| per_pdata_o | output | 8 | Head byte seen by the peripheral side |
| per_ptag_o | output | 1 | Head tag seen by the peripheral side |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| thresh_irq_o | output | 1 | Threshold interrupt |

## Verification
The bench fills the queue to 16 entries and then writes once more. A design that accepted that write would overwrite the oldest entry or wrap the count, and the scoreboard would catch it while draining. It pops and reads on an empty queue and then sends one fresh byte through. A pointer that slipped on underflow would return a stale byte instead of the new one. Writes and reads go through aliases that are closed in the current mode or direction. A design with loose gating would store phantom entries, which show up as a missing empty flag, or it would consume a byte that the peripheral side still expects. The interrupt is checked on both sides of the threshold in each direction, so a design that swapped free space and filled space, or used a strict compare, fails there.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;
  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_COMPAT = 2'd1,
    SEL_ECP    = 2'd2,
    SEL_TEST   = 2'd3
  } alias_e;

  localparam logic [2:0] MODE_COMPAT = 3'b010;
  localparam logic [2:0] MODE_ECP    = 3'b011;
  localparam logic [2:0] MODE_TEST   = 3'b110;
endpackage

// File: rtl/pp_host_gate.sv
module pp_host_gate #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          dir_rev_i,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          per_push_i,
  input  logic [DW-1:0] per_pdata_i,
  input  logic          per_ptag_i,
  input  logic          per_pop_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [DW:0]   push_entry_o,
  output logic          host_rd_ok_o,
  output logic          per_view_o
);
  import pp_fifo_pkg::*;

  alias_e sel;
  logic   test_m, ecp_m, compat_m, wr_ok, rd_ok, pp_push, pp_pop;

  assign sel      = alias_e'(sel_i);
  assign test_m   = (mode_i == MODE_TEST);
  assign ecp_m    = (mode_i == MODE_ECP);
  assign compat_m = (mode_i == MODE_COMPAT);

  always_comb begin
    wr_ok = 1'b0;
    rd_ok = 1'b0;
    unique case (sel)
      SEL_CMD:    wr_ok = ecp_m && !dir_rev_i;
      SEL_COMPAT: wr_ok = compat_m && !dir_rev_i;
      SEL_ECP: begin
        wr_ok = ecp_m && !dir_rev_i;
        rd_ok = ecp_m && dir_rev_i;
      end
      SEL_TEST: begin
        wr_ok = test_m;
        rd_ok = test_m;
      end
    endcase
    wr_ok = wr_ok && wr_i;
    rd_ok = rd_ok && rd_i;
  end

  // peripheral port idles in test mode
  assign pp_push    = per_push_i && dir_rev_i && !test_m;
  assign pp_pop     = per_pop_i && !dir_rev_i && !test_m;
  assign per_view_o = !dir_rev_i && !test_m;

  assign push_o       = wr_ok || pp_push;
  assign pop_o        = rd_ok || pp_pop;
  assign host_rd_ok_o = rd_ok;
  assign push_entry_o = wr_ok ? {(sel == SEL_CMD), host_wdata_i} : {per_ptag_i, per_pdata_i};

  a_r8_no_host_pop_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rev_i && !test_m) |-> !host_rd_ok_o);
  a_r7_test_idles_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_m && !wr_i && !rd_i) |-> (!push_o && !pop_o));
endmodule

// File: rtl/pp_fifo_store.sv
module pp_fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  a_r4_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
  a_r4_no_underflow_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/pp_fifo_thresh.sv
module pp_fifo_thresh #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_rev_i,
  input  logic [CW-1:0] count_i,
  input  logic [TW-1:0] thresh_i,
  output logic          irq_o
);
  logic [CW-1:0] level;

  // forward watches free room, reverse watches fill
  assign level = dir_rev_i ? count_i : CW'(DEPTH) - count_i;
  assign irq_o = (level >= CW'(thresh_i));

  a_r9_fwd_empty_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rev_i && count_i == '0) |-> irq_o);
  a_r10_rev_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rev_i && count_i == '0 && thresh_i != '0) |-> !irq_o);
endmodule

// File: rtl/pp_tag_fifo.sv
module pp_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          dir_rev_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [1:0]    host_sel_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_rtag_o,
  input  logic          per_push_i,
  input  logic [DW-1:0] per_pdata_i,
  input  logic          per_ptag_i,
  input  logic          per_pop_i,
  output logic [DW-1:0] per_pdata_o,
  output logic          per_ptag_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          thresh_irq_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 1;

  logic          push, pop, rd_ok, per_view;
  logic [EW-1:0] push_entry, head;
  logic [CW-1:0] count;

  pp_host_gate #(.DW(DW)) u_gate (
    .clk_i, .rst_ni, .mode_i, .dir_rev_i,
    .sel_i(host_sel_i), .wr_i(host_wr_i), .rd_i(host_rd_i),
    .host_wdata_i, .per_push_i, .per_pdata_i, .per_ptag_i, .per_pop_i,
    .push_o(push), .pop_o(pop), .push_entry_o(push_entry),
    .host_rd_ok_o(rd_ok), .per_view_o(per_view)
  );

  pp_fifo_store #(.DEPTH(DEPTH), .W(EW), .CW(CW)) u_store (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(push_entry), .pop_i(pop),
    .head_o(head), .empty_o, .full_o, .count_o(count)
  );

  pp_fifo_thresh #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) u_thresh (
    .clk_i, .rst_ni, .dir_rev_i, .count_i(count), .thresh_i, .irq_o(thresh_irq_o)
  );

  // undefined reads drive zero
  assign {host_rtag_o, host_rdata_o} = (rd_ok && !empty_o) ? head : '0;
  assign {per_ptag_o, per_pdata_o}   = (per_view && !empty_o) ? head : '0;

  a_r11_closed_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !rd_ok) |-> (host_rdata_o == '0 && !host_rtag_o));
  a_r4_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (host_rdata_o == '0 && per_pdata_o == '0));
  a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

// File: tb/pp_tag_fifo_test.sv
module pp_tag_fifo_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic       clk = 0, rst_n = 0;
  logic [2:0] mode = 3'b011;
  logic       rev = 0;
  logic [3:0] thresh = 4'd8;
  logic [1:0] sel = 0;
  logic       hwr = 0, hrd = 0, ppush = 0, ppop = 0, ptag_in = 0;
  logic [7:0] wdata = 0, pdata_in = 0;
  logic [7:0] host_rdata, per_pdata;
  logic       host_rtag, per_ptag, empty, full, irq;

  logic [8:0] q[$];
  logic [8:0] e;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  pp_tag_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dir_rev_i(rev), .thresh_i(thresh),
    .host_sel_i(sel), .host_wr_i(hwr), .host_rd_i(hrd), .host_wdata_i(wdata),
    .host_rdata_o(host_rdata), .host_rtag_o(host_rtag),
    .per_push_i(ppush), .per_pdata_i(pdata_in), .per_ptag_i(ptag_in), .per_pop_i(ppop),
    .per_pdata_o(per_pdata), .per_ptag_o(per_ptag),
    .empty_o(empty), .full_o(full), .thresh_irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic wr_open(logic [1:0] s);
    case (s)
      2'd0, 2'd2: return mode == 3'b011 && !rev;
      2'd1:       return mode == 3'b010 && !rev;
      default:    return mode == 3'b110;
    endcase
  endfunction

  function automatic logic rd_open(logic [1:0] s);
    if (s == 2'd2) return mode == 3'b011 && rev;
    if (s == 2'd3) return mode == 3'b110;
    return 1'b0;
  endfunction

  // driver tasks: start and end at posedge+1
  task automatic host_write(logic [1:0] s, logic [7:0] d);
    sel = s; wdata = d; hwr = 1;
    if (wr_open(s) && q.size() < DEPTH) q.push_back({(s == 2'd0), d});
    @(posedge clk); #1 hwr = 0;
  endtask

  task automatic host_read(logic [1:0] s, bit chk_zero, string req);
    sel = s; hrd = 1;
    @(negedge clk);
    if (chk_zero) begin
      check(req, {23'd0, host_rtag, host_rdata}, 32'd0);
    end
    @(posedge clk); #1 hrd = 0;
  endtask

  task automatic per_push(logic [7:0] d, logic t);
    pdata_in = d; ptag_in = t; ppush = 1;
    if (rev && mode != 3'b110 && q.size() < DEPTH) q.push_back({t, d});
    @(posedge clk); #1 ppush = 0;
  endtask

  task automatic per_pop(int n);
    for (int i = 0; i < n; i++) begin
      ppop = 1;
      @(posedge clk); #1 ppop = 0;
    end
  endtask

  task automatic check_irq(string req);
    logic exp_irq;
    exp_irq = rev ? (q.size() >= int'(thresh)) : ((DEPTH - q.size()) >= int'(thresh));
    check(req, {31'd0, irq}, {31'd0, exp_irq});
  endtask

  // monitor: compares every consumed entry against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ppop && !rev && mode != 3'b110 && q.size() > 0) begin
        e = q.pop_front();
        check("R2", {23'd0, per_ptag, per_pdata}, {23'd0, e});
      end
      if (hrd && rd_open(sel) && q.size() > 0) begin
        e = q.pop_front();
        check((mode == 3'b110) ? "R7" : "R5", {23'd0, host_rtag, host_rdata}, {23'd0, e});
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1", {31'd0, empty}, 32'd1);
    check("R1", {31'd0, full}, 32'd0);
    check("R1", {24'd0, host_rdata}, 32'd0);
    check("R1", {24'd0, per_pdata}, 32'd0);
    check_irq("R9");

    // R8 peripheral push in forward ignored
    per_push(8'h55, 1'b1);
    check("R8", {31'd0, empty}, 32'd1);

    // R2 tags and order, R6 gating in compat mode
    host_write(2'd0, 8'hA1);
    host_write(2'd2, 8'h12);
    host_write(2'd2, 8'h34);
    mode = 3'b010;
    host_write(2'd1, 8'h56);
    host_write(2'd2, 8'h99);
    host_write(2'd0, 8'h98);
    per_pop(4);
    check("R6", {31'd0, empty}, 32'd1);
    mode = 3'b000;
    host_write(2'd1, 8'h77);
    host_write(2'd3, 8'h78);
    check("R6", {31'd0, empty}, 32'd1);

    // R3 fill and overflow
    mode = 3'b011;
    for (int i = 0; i < DEPTH; i++) host_write(2'(i % 3 == 0 ? 0 : 2), 8'(8'h40 + i));
    check("R3", {31'd0, full}, 32'd1);
    check_irq("R9");
    host_write(2'd2, 8'hEE);
    check("R3", {31'd0, full}, 32'd1);
    check("R3", {31'd0, empty}, 32'd0);
    per_pop(7);
    check_irq("R9");
    per_pop(1);
    check_irq("R9");
    per_pop(8);
    check("R3", {31'd0, empty}, 32'd1);

    // R4 underflow leaves pointers in place
    per_pop(2);
    check("R4", {31'd0, empty}, 32'd1);
    check("R4", {24'd0, per_pdata}, 32'd0);
    host_write(2'd2, 8'h3C);
    per_pop(1);

    // R11 host read in forward consumes nothing
    host_write(2'd0, 8'h5A);
    host_read(2'd2, 1'b1, "R11");
    host_read(2'd1, 1'b1, "R11");
    check("R11", {31'd0, empty}, 32'd0);
    per_pop(1);

    // R4 host read on empty in reverse
    rev = 1;
    host_read(2'd2, 1'b1, "R4");
    check("R4", {31'd0, empty}, 32'd1);
    host_write(2'd2, 8'h11);
    check("R8", {31'd0, empty}, 32'd1);

    // R5 / R10 reverse direction
    thresh = 4'd5;
    for (int i = 0; i < 4; i++) per_push(8'(8'hB0 + i), 1'(i % 2));
    check_irq("R10");
    per_push(8'hC5, 1'b1);
    check_irq("R10");
    for (int i = 0; i < 5; i++) host_read(2'd2, 1'b0, "R5");
    check("R5", {31'd0, empty}, 32'd1);

    // R7 test alias both directions
    mode = 3'b110;
    for (int i = 0; i < 3; i++) host_write(2'd3, 8'(8'hC1 + i));
    per_push(8'hDD, 1'b1);
    check("R7", {31'd0, empty}, 32'd0);
    for (int i = 0; i < 3; i++) host_read(2'd3, 1'b0, "R7");
    check("R7", {31'd0, empty}, 32'd1);
    rev = 0;
    host_write(2'd3, 8'h61);
    host_write(2'd3, 8'h62);
    per_pop(1);
    check("R7", {31'd0, empty}, 32'd0);
    host_read(2'd3, 1'b0, "R7");
    host_read(2'd3, 1'b0, "R7");
    check("R7", {31'd0, empty}, 32'd1);
    check("R7", q.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule